// File: doc/BRIEF.md
# Gapless Symbol Pulse Train Generator

This block turns a stream of 2-bit symbols into a single-bit waveform on a fixed time grid. Every symbol fills whole slots of `SLOT_CYCLES` clock cycles. A low symbol holds the pin at 0 for one slot. A short symbol drives it high for one slot. A long symbol keeps it high for two slots in a row, with no dip at the slot edge between them. Symbols are played back to back with no idle cycle between them, so an edge can only occur on a slot boundary.

A frame begins with a one-cycle `start_i`, which also captures a symbol count. Symbols are taken over a valid/ready handshake. `sym_ready_o` is raised only in the last cycle of a slot that needs a successor, so the new level reaches the output flop on the same edge that ends the old slot. If no symbol is offered at that point, the generator plays a low slot and flags an underrun. When the counted symbols are used up, a one-cycle done pulse follows and the pin stays low until the next frame.

Top module: `pulse_train_gen`

## Requirements
- R1: While `rst_n` is low, and after reset, `pulse_o`, `done_o`, `underrun_o`, `bad_code_o` and `sym_ready_o` are all 0.
- R2: Code 2'b00 holds `pulse_o` low for exactly `SLOT_CYCLES` cycles. Code 2'b01 holds it high for exactly `SLOT_CYCLES` cycles.
- R3: Code 2'b10 holds `pulse_o` high for exactly 2×`SLOT_CYCLES` consecutive cycles with no low cycle inside, and it consumes one symbol.
- R4: A long symbol causes no `sym_ready_o` at its internal slot boundary. Over a frame, the number of ready cycles equals the number of symbols plus the number of underrun slots.
- R5: Consecutive slots abut with no idle cycle. `pulse_o` changes only on the clock edge that ends a slot, so the output waveform equals the concatenated expansion of the symbols, cycle for cycle.
- R6: `start_i` is sampled at an edge E0 while idle. `sym_ready_o` is high in the following cycle (when the count is non-zero). A symbol accepted at a ready edge sets the level seen from the next cycle on, and later ready cycles occur only in the last cycle of a slot.
- R7: `frame_len_i`, captured at start, is the number of symbols accepted. After the last slot, `done_o` is high for exactly one cycle. In that cycle `pulse_o` is low, and it stays low with no further ready until the next start. A count of 0 gives `done_o` in the second cycle after E0.
- R8: If `sym_valid_i` is low in a ready cycle, the next slot is low, no symbol is consumed, and `underrun_o` is set and held until the next start.
- R9: Code 2'b11 plays as a low slot, consumes one symbol, and sets `bad_code_o`, which is held until the next start.
- R10: `start_i` asserted while a frame is running has no effect on the waveform, the symbol count or the done timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin a frame (sampled while idle) |
| frame_len_i | input | CNT_W | Number of symbols in the frame |
| sym_i | input | 2 | Symbol code |
| sym_valid_i | input | 1 | Symbol code is valid |
| sym_ready_o | output | 1 | Symbol taken at this edge if valid |
| pulse_o | output | 1 | Registered waveform output |
| done_o | output | 1 | One-cycle end-of-frame pulse |
| underrun_o | output | 1 | A boundary found no symbol in this frame |
| bad_code_o | output | 1 | A reserved code was played in this frame |

## Verification
After start is sampled at edge E0, ready is due in the next cycle. The waveform starts one edge later, and a symbol's level shows from the cycle after the edge that accepts it. Done is due exactly slots×`SLOT_CYCLES` cycles after that first symbol edge. The bench drives inputs and samples outputs on falling edges. It records every cycle from the first slot until done and compares each one with the level expanded from the symbol list; one extra low slot is prepended when an underrun is provoked. Ready cycles and handshakes are counted over the frame and compared with the symbol count, and the quiet period after done is checked cycle by cycle.

// File: rtl/pt_pkg.sv
// Shared symbol encoding for the pulse train generator.
// Assumes a 2-bit code; 2'b11 is reserved.
package pt_pkg;
    localparam int SYM_W = 2;

    typedef enum logic [SYM_W-1:0] {
        SYM_LOW   = 2'b00,
        SYM_SHORT = 2'b01,
        SYM_LONG  = 2'b10,
        SYM_RSVD  = 2'b11
    } sym_e;
endpackage

// File: rtl/pt_slot_timer.sv
// Slot timer: counts cycles inside a slot and flags the last cycle.
// Assumes SLOT_CYCLES >= 2. A load puts the counter on the last cycle,
// so the first boundary follows one cycle after the load.
module pt_slot_timer #(
    parameter int SLOT_CYCLES = 30
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic run_i,
    output logic slot_end_o
);
    localparam int CW = (SLOT_CYCLES > 1) ? $clog2(SLOT_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(SLOT_CYCLES - 1);

    logic [CW-1:0] cnt_q;

    // Advance the in-slot cycle counter, wrapping at the slot length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= LAST;
        end else if (run_i) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    // Boundary flag: last cycle of the current slot while running.
    always_comb slot_end_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/pt_sym_decode.sv
// Symbol decoder: maps a code to the first-slot level, a two-slot flag
// and a reserved-code flag. Purely combinational.
module pt_sym_decode
    import pt_pkg::*;
(
    input  logic [SYM_W-1:0] code_i,
    output logic             level_o,
    output logic             long_o,
    output logic             bad_o
);
    // Decode one symbol; reserved codes play as a low slot.
    always_comb begin
        level_o = 1'b0;
        long_o  = 1'b0;
        bad_o   = 1'b0;
        case (sym_e'(code_i))
            SYM_SHORT: level_o = 1'b1;
            SYM_LONG: begin
                level_o = 1'b1;
                long_o  = 1'b1;
            end
            SYM_RSVD: bad_o = 1'b1;
            default: level_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/pt_frame_ctr.sv
// Frame counter: holds the number of symbols still to accept.
// Assumes load and decrement are never requested in the same cycle.
module pt_frame_ctr #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] len_i,
    input  logic             dec_i,
    output logic [CNT_W-1:0] left_o,
    output logic             empty_o
);
    logic [CNT_W-1:0] left_q;

    // Load the frame length at start, count down per accepted symbol.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (load_i) begin
            left_q <= len_i;
        end else if (dec_i && left_q != '0) begin
            left_q <= left_q - 1'b1;
        end
    end

    // Expose the count and its empty condition.
    always_comb begin
        left_o  = left_q;
        empty_o = (left_q == '0);
    end
endmodule

// File: rtl/pulse_train_gen.sv
// Gapless symbol pulse train generator (top).
// Plays 2-bit symbols onto a registered output on a grid of SLOT_CYCLES
// cycles. A symbol is fetched in the last cycle of a slot so that it
// takes effect on the edge ending that slot. Assumes the symbol source
// holds sym_i stable while sym_valid_i is high.
module pulse_train_gen
    import pt_pkg::*;
#(
    parameter int SLOT_CYCLES = 30,
    parameter int CNT_W       = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [CNT_W-1:0] frame_len_i,
    input  logic [SYM_W-1:0] sym_i,
    input  logic             sym_valid_i,
    output logic             sym_ready_o,
    output logic             pulse_o,
    output logic             done_o,
    output logic             underrun_o,
    output logic             bad_code_o
);
    logic             running_q;
    logic             second_half_q;
    logic             slot_end;
    logic             launch;
    logic             accept;
    logic             frame_empty;
    logic [CNT_W-1:0] remaining_q;
    logic             dec_level;
    logic             dec_long;
    logic             dec_bad;

    // Frame launch only while idle; a start during a frame is ignored.
    always_comb launch = start_i && !running_q;

    pt_slot_timer #(
        .SLOT_CYCLES(SLOT_CYCLES)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (launch),
        .run_i     (running_q),
        .slot_end_o(slot_end)
    );

    pt_frame_ctr #(
        .CNT_W(CNT_W)
    ) u_count (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (launch),
        .len_i  (frame_len_i),
        .dec_i  (accept),
        .left_o (remaining_q),
        .empty_o(frame_empty)
    );

    pt_sym_decode u_dec (
        .code_i (sym_i),
        .level_o(dec_level),
        .long_o (dec_long),
        .bad_o  (dec_bad)
    );

    // Ready only at a boundary that needs a new symbol.
    always_comb begin
        sym_ready_o = slot_end && !second_half_q && !frame_empty;
        accept      = sym_ready_o && sym_valid_i;
    end

    // Frame sequencing and the registered output pin.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running_q     <= 1'b0;
            second_half_q <= 1'b0;
            pulse_o       <= 1'b0;
            done_o        <= 1'b0;
            underrun_o    <= 1'b0;
            bad_code_o    <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (launch) begin
                running_q     <= 1'b1;
                second_half_q <= 1'b0;
                pulse_o       <= 1'b0;
                underrun_o    <= 1'b0;
                bad_code_o    <= 1'b0;
            end else if (slot_end) begin
                if (second_half_q) begin
                    second_half_q <= 1'b0;
                end else if (frame_empty) begin
                    running_q <= 1'b0;
                    pulse_o   <= 1'b0;
                    done_o    <= 1'b1;
                end else if (sym_valid_i) begin
                    pulse_o       <= dec_level;
                    second_half_q <= dec_long;
                    if (dec_bad) begin
                        bad_code_o <= 1'b1;
                    end
                end else begin
                    pulse_o    <= 1'b0;
                    underrun_o <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/pt_checker.sv
// Checker for pulse_train_gen: timing properties of the output grid,
// the handshake and the end of frame. Attached by bind below.
module pt_checker #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pulse_o,
    input logic             done_o,
    input logic             sym_ready_o,
    input logic             underrun_o,
    input logic             slot_end,
    input logic             running_q,
    input logic [CNT_W-1:0] remaining_q
);
    // R6: a fetch is only offered on the last cycle of a slot.
    p_ready_on_grid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sym_ready_o |-> slot_end);

    // R5: the output moves only on the edge that closes a slot.
    p_edge_on_grid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_o != $past(pulse_o)) |-> $past(slot_end));

    // R7: done lasts a single cycle.
    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R7: at done the pin is low and the frame has stopped.
    p_done_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!pulse_o && !running_q));

    // R7: no fetch once the counted symbols are used up.
    p_no_fetch_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sym_ready_o |-> (remaining_q != '0));

    // R8: a starved boundary leaves the pin low.
    p_underrun_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(underrun_o) |-> !pulse_o);

    // R1: nothing is offered or driven while idle.
    p_idle_silent_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !running_q |-> (!sym_ready_o && !pulse_o));
endmodule

bind pulse_train_gen pt_checker #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pulse_o    (pulse_o),
    .done_o     (done_o),
    .sym_ready_o(sym_ready_o),
    .underrun_o (underrun_o),
    .slot_end   (slot_end),
    .running_q  (running_q),
    .remaining_q(remaining_q)
);

// File: tb/sim_pulse_train_gen.sv
// Bench for pulse_train_gen: plays frames and compares every output
// cycle with the level expanded from the symbol list.
module sim_pulse_train_gen;
    localparam int SLOT  = 30;
    localparam int CNT_W = 8;
    localparam int MAXC  = 8192;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [CNT_W-1:0] frame_len_i = '0;
    logic [1:0]       sym_i;
    logic             sym_valid_i;
    logic             sym_ready_o, pulse_o, done_o, underrun_o, bad_code_o;

    logic [1:0] syms [0:255];
    bit         tr [0:MAXC-1];
    bit         ex [0:MAXC-1];
    int         idx = 0;
    bit         idx_clr = 1'b0;
    bit         gate = 1'b1;
    int         nsym = 0;
    int         checks = 0;
    int         errors = 0;
    int         cyc = 0;

    always #2 clk = ~clk;

    pulse_train_gen #(.SLOT_CYCLES(SLOT), .CNT_W(CNT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .frame_len_i(frame_len_i),
        .sym_i(sym_i), .sym_valid_i(sym_valid_i), .sym_ready_o(sym_ready_o),
        .pulse_o(pulse_o), .done_o(done_o), .underrun_o(underrun_o),
        .bad_code_o(bad_code_o)
    );

    // Symbol source: present the next listed symbol while gated on.
    always_comb begin
        sym_valid_i = gate && (idx < nsym);
        sym_i       = (idx < nsym) ? syms[idx] : 2'b00;
    end

    always @(posedge clk) begin
        if (idx_clr) idx <= 0;
        else if (sym_ready_o && sym_valid_i) idx <= idx + 1;
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: act %0d cycles exp < 150000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s %s: act %0d exp %0d", req, what, act, exp);
        end
    endtask

    // Play one frame of n symbols; lead adds a starved first boundary,
    // mid_start pulses start_i during the frame.
    task automatic run_frame(input int n, input bit lead, input bit mid_start,
                             input bit exp_bad, input string req);
        int e = 0;
        int k = 0;
        int kd = -1;
        int rdy = 0;
        int hs = 0;
        int bad = 0;
        int first_bad = -1;
        int quiet_bad = 0;
        if (lead) for (int c = 0; c < SLOT; c++) begin ex[e] = 1'b0; e++; end
        for (int s = 0; s < n; s++) begin
            int len = (syms[s] == 2'b10) ? 2 * SLOT : SLOT;
            bit lvl = (syms[s] == 2'b01) || (syms[s] == 2'b10);
            for (int c = 0; c < len; c++) begin ex[e] = lvl; e++; end
        end
        nsym = n;
        @(negedge clk);
        idx_clr = 1'b1;
        gate = !lead;
        start_i = 1'b1;
        frame_len_i = CNT_W'(n);
        @(posedge clk);
        @(negedge clk);
        idx_clr = 1'b0;
        start_i = 1'b0;
        check(sym_ready_o == (n > 0), "R6", "ready after start", sym_ready_o, n > 0);
        if (sym_ready_o) begin rdy++; if (sym_valid_i) hs++; end
        while (kd < 0 && k < MAXC) begin
            @(negedge clk);
            gate = 1'b1;
            if (mid_start) start_i = (k == 45);
            tr[k] = pulse_o;
            if (done_o) kd = k;
            else if (sym_ready_o) begin rdy++; if (sym_valid_i) hs++; end
            k++;
        end
        start_i = 1'b0;
        check(kd == e, req, "done cycle", kd, e);
        for (int c = 0; c < e && c < kd; c++)
            if (tr[c] != ex[c]) begin bad++; if (first_bad < 0) first_bad = c; end
        check(bad == 0, req, "waveform mismatches (first index)", first_bad, -1);
        check(hs == n, "R7", "symbols accepted", hs, n);
        check(rdy == n + (lead ? 1 : 0), "R4", "ready cycles", rdy, n + (lead ? 1 : 0));
        check(underrun_o == lead, "R8", "underrun flag", underrun_o, lead);
        check(bad_code_o == exp_bad, "R9", "bad code flag", bad_code_o, exp_bad);
        for (int c = 0; c < 40; c++) begin
            @(negedge clk);
            if (done_o || pulse_o || sym_ready_o) quiet_bad++;
        end
        check(quiet_bad == 0, "R7", "busy cycles after done", quiet_bad, 0);
    endtask

    initial begin
        int lf;
        for (int i = 0; i < 256; i++) syms[i] = 2'b00;
        repeat (3) @(negedge clk);
        check({pulse_o, done_o, underrun_o, bad_code_o, sym_ready_o} == 5'b0,
              "R1", "outputs in reset", pulse_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check({pulse_o, done_o, underrun_o, bad_code_o, sym_ready_o} == 5'b0,
              "R1", "outputs after reset", pulse_o, 0);

        // R2: alternating short and low slots.
        for (int i = 0; i < 8; i++) syms[i] = (i % 2 == 0) ? 2'b01 : 2'b00;
        run_frame(8, 1'b0, 1'b0, 1'b0, "R2");

        // R3: only long pulses, no fetch at their middle boundary.
        for (int i = 0; i < 6; i++) syms[i] = 2'b10;
        run_frame(6, 1'b0, 1'b0, 1'b0, "R3");

        // R5: mixed pattern with short pairs next to long pulses.
        syms[0] = 2'b01; syms[1] = 2'b01; syms[2] = 2'b10; syms[3] = 2'b00;
        syms[4] = 2'b10; syms[5] = 2'b10; syms[6] = 2'b01; syms[7] = 2'b00;
        syms[8] = 2'b00; syms[9] = 2'b01;
        run_frame(10, 1'b0, 1'b0, 1'b0, "R5");

        // R5: 60 and 120 pseudo-random symbols from a small LFSR.
        lf = 8'h5b;
        for (int i = 0; i < 120; i++) begin
            lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]} & 8'hff;
            syms[i] = 2'(lf % 3);
        end
        run_frame(60, 1'b0, 1'b0, 1'b0, "R5");
        run_frame(120, 1'b0, 1'b0, 1'b0, "R5");

        // R7: empty frame gives done with no symbol taken.
        run_frame(0, 1'b0, 1'b0, 1'b0, "R7");

        // R8: starved first boundary inserts one low slot.
        for (int i = 0; i < 5; i++) syms[i] = (i == 2) ? 2'b10 : 2'b01;
        run_frame(5, 1'b1, 1'b0, 1'b0, "R8");

        // R9: reserved code plays low and is flagged; flags cleared by start.
        syms[0] = 2'b01; syms[1] = 2'b11; syms[2] = 2'b01; syms[3] = 2'b10;
        run_frame(4, 1'b0, 1'b0, 1'b1, "R9");

        // R10: start pulsed mid-frame changes nothing.
        for (int i = 0; i < 7; i++) syms[i] = (i % 3 == 0) ? 2'b10 : 2'b01;
        run_frame(7, 1'b0, 1'b1, 1'b0, "R10");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule